// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous Memory

This block is a single-port synchronous memory front end. Reads and writes can follow each other in any order at full clock rate, with no idle cycle between them. Address, controls and byte masks are registered on the rising clock edge, but only when the active-low clock enable is asserted. Three chip selects decide whether a load cycle starts an operation. A load strobe either starts a new access at an external address or continues the running access through a two-bit burst counter. The burst follows a linear or an interleaved order.

Read data is flow-through: it appears combinationally from the registered address during the cycle that follows the command edge. Write data follows its command by one enabled edge. That data is parked in a one-entry pending-write holder and committed to the array on the next enabled edge. A read that hits the parked address sees the new bytes merged over the array contents. The data bus is modelled as a value output plus a drive-enable output.

Top module: `ftsram_ctrl`

## Requirements
- R1: While `clk_en_n` is high, no input is sampled and all state (operation, burst position, pending write, array) holds, so `rdata` and `rdata_oe` keep their values.
- R2: A load cycle (`adv_ld`=0) selects the block only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other combination is a deselect: no operation runs and `rdata_oe` is 0 in the following cycle.
- R3: A selected load cycle starts a read at `addr` when `wr_n`=1 and a write at `addr` when `wr_n`=0.
- R4: With `adv_ld`=1, a running read or write advances to its next burst address, and an idle state stays idle (continued deselect). The counter wraps after four beats.
- R5: When `burst_ilv`=1 at the load edge, beat k (k=0..3, modulo 4) uses address bits [1:0] equal to base[1:0] XOR k.
- R6: When `burst_ilv`=0 at the load edge, beat k uses base[1:0]+k modulo 4. Bits above bit 1 stay at the loaded value.
- R7: Each beat's `byte_wr_n` is sampled with that beat. Its data is sampled on the next enabled edge. Lane i is bits [9i+8:9i] (eight data bits, with the parity bit at 9i+8), and lane i is written only if `byte_wr_n[i]`=0. A beat with all masks high writes nothing.
- R8: During a read, `byte_wr_n` and `wdata` have no effect on the array.
- R9: Read data for a command taken on an edge is on `rdata` during the very next cycle. Alternating reads and writes need no wait or idle cycle.
- R10: A read of the address whose write data is pending returns the newly written lanes merged over the older contents.
- R11: `rdata_oe` is 1 only while a read is active and `oe_n`=0. Otherwise it is 0 and `rdata` is all zero.
- R12: After reset, no operation is active, `rdata_oe` is 0 and every array word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| wr_n | input | 1 | 0 = write, 1 = read (on load) |
| burst_ilv | input | 1 | Burst order taken at load: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| byte_wr_n | input | LANES | Active-low per-lane write masks |
| wdata | input | LANES*LW | Write data, one enabled edge after its beat |
| oe_n | input | 1 | Active-low output enable |
| rdata | output | LANES*LW | Read data (zero when not driven) |
| rdata_oe | output | 1 | Drive enable of the data bus |

## Verification
A wrong burst position shows on `rdata` in the same cycle as the advance edge, because the read value comes from the array word at the wrong address. A pending-write holder that drops, misplaces or mis-merges its lanes shows on the first read of that address, or of the next address it is committed to, which is often the very next cycle in a write-then-read pair. A stall that leaks state shows as a change on `rdata` during the stalled cycles or a shifted sequence afterwards. The bench sweeps every base address in both burst orders through a full wrap, and every chip-select combination, against a word-level model in the bench.

// File: rtl/ftsram_pkg.sv
`timescale 1ns/1ps
package ftsram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/ftsram_burst.sv
`timescale 1ns/1ps
module ftsram_burst #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic          step,
    input  logic          ilv_in,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr
);
    localparam int CW = 2;

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
        logic          ilv;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic [CW-1:0] low;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (load) begin
                st_d.base = load_addr;
                st_d.cnt  = '0;
                st_d.ilv  = ilv_in;
            end else if (step) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_comb begin
        if (st_q.ilv) low = st_q.base[CW-1:0] ^ st_q.cnt;
        else          low = st_q.base[CW-1:0] + st_q.cnt;
        cur_addr = {st_q.base[AW-1:CW], low};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !load) |=> (cur_addr[AW-1:CW] == $past(cur_addr[AW-1:CW]))); // R6
endmodule

// File: rtl/ftsram_registry.sv
`timescale 1ns/1ps
module ftsram_registry #(
    parameter int AW    = 4,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                capture,
    input  logic [AW-1:0]       cap_addr,
    input  logic [LANES-1:0]    cap_mask,
    input  logic [LANES*LW-1:0] cap_data,
    input  logic [AW-1:0]       lk_addr,
    input  logic [LANES*LW-1:0] lk_word,
    output logic [LANES*LW-1:0] lk_merged,
    output logic                pend_valid,
    output logic [AW-1:0]       pend_addr,
    output logic [LANES-1:0]    pend_mask,
    output logic [LANES*LW-1:0] pend_data
);
    localparam int DW = LANES * LW;

    typedef struct packed {
        logic             valid;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] mask;
        logic [DW-1:0]    data;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.valid = capture;
            if (capture) begin
                st_d.addr = cap_addr;
                st_d.mask = cap_mask;
                st_d.data = cap_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.valid && (st_q.addr == lk_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lk_merged[l*LW +: LW] = (hit && st_q.mask[l]) ? st_q.data[l*LW +: LW]
                                                             : lk_word[l*LW +: LW];
    end

    assign pend_valid = st_q.valid;
    assign pend_addr  = st_q.addr;
    assign pend_mask  = st_q.mask;
    assign pend_data  = st_q.data;

    AST_REG_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && capture) |=> (pend_valid && pend_addr == $past(cap_addr))); // R10
    AST_REG_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q)); // R1
endmodule

// File: rtl/ftsram_array.sv
`timescale 1ns/1ps
module ftsram_array #(
    parameter int AW    = 4,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES-1:0]    wmask,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wmask[l]) mem_d[waddr][l*LW +: LW] = wdata[l*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ftsram_ctrl.sv
`timescale 1ns/1ps
module ftsram_ctrl #(
    parameter int AW    = 4,
    parameter int LANES = 2,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic                cs_a_n,
    input  logic                cs_b,
    input  logic                cs_c_n,
    input  logic                adv_ld,
    input  logic                wr_n,
    input  logic                burst_ilv,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    byte_wr_n,
    input  logic [LANES*LW-1:0] wdata,
    input  logic                oe_n,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_oe
);
    import ftsram_pkg::*;
    localparam int DW = LANES * LW;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] mask;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    en, sel, load, step;

    logic [AW-1:0]    cur_addr;
    logic [DW-1:0]    arr_word, merged;
    logic             pend_valid;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic [DW-1:0]    pend_data;

    always_comb begin
        en   = !clk_en_n;
        sel  = !cs_a_n && cs_b && !cs_c_n;
        st_d = st_q;
        load = 1'b0;
        step = 1'b0;
        if (en) begin
            if (!adv_ld) begin
                load = sel;
                if (!sel)      st_d.op = OP_IDLE;
                else if (wr_n) st_d.op = OP_READ;
                else           st_d.op = OP_WRITE;
                st_d.mask = (sel && !wr_n) ? ~byte_wr_n : '0;
            end else if (st_q.op != OP_IDLE) begin
                step      = 1'b1;
                st_d.mask = (st_q.op == OP_WRITE) ? ~byte_wr_n : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{op: OP_IDLE, mask: '0};
        else        st_q <= st_d;
    end

    ftsram_burst #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load     (load),
        .step     (step),
        .ilv_in   (burst_ilv),
        .load_addr(addr),
        .cur_addr (cur_addr)
    );

    ftsram_registry #(.AW(AW), .LANES(LANES), .LW(LW)) u_registry (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .capture   (st_q.op == OP_WRITE),
        .cap_addr  (cur_addr),
        .cap_mask  (st_q.mask),
        .cap_data  (wdata),
        .lk_addr   (cur_addr),
        .lk_word   (arr_word),
        .lk_merged (merged),
        .pend_valid(pend_valid),
        .pend_addr (pend_addr),
        .pend_mask (pend_mask),
        .pend_data (pend_data)
    );

    ftsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (en && pend_valid),
        .waddr(pend_addr),
        .wmask(pend_mask),
        .wdata(pend_data),
        .raddr(cur_addr),
        .rdata(arr_word)
    );

    assign rdata_oe = (st_q.op == OP_READ) && !oe_n;
    assign rdata    = rdata_oe ? merged : '0;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(st_q) && $stable(cur_addr))); // R1
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !(!cs_a_n && cs_b && !cs_c_n)) |=> !rdata_oe); // R2
    AST_READ_LEAVES_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && st_q.op != OP_WRITE) |=> !pend_valid); // R8
    AST_READ_STARTS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !cs_a_n && cs_b && !cs_c_n && wr_n) |=> (st_q.op == OP_READ)); // R9
endmodule

// File: tb/ftsram_ctrl_tb.sv
`timescale 1ns/1ps
module ftsram_ctrl_tb;
    localparam int AW = 4;
    localparam int LANES = 2;
    localparam int LW = 9;
    localparam int DW = LANES * LW;

    logic clk = 1'b0;
    logic rst_n, clk_en_n, cs_a_n, cs_b, cs_c_n, adv_ld, wr_n, burst_ilv, oe_n;
    logic [AW-1:0] addr;
    logic [LANES-1:0] byte_wr_n;
    logic [DW-1:0] wdata, rdata;
    logic rdata_oe;

    logic [DW-1:0] mdl [16];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ftsram_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
        .cs_c_n(cs_c_n), .adv_ld(adv_ld), .wr_n(wr_n), .burst_ilv(burst_ilv),
        .addr(addr), .byte_wr_n(byte_wr_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [DW-1:0] dat(input int i);
        return DW'(i * 9973 + 1234);
    endfunction

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int k, input bit ilv);
        logic [1:0] kk;
        kk = k[1:0];
        return {b[AW-1:2], ilv ? (b[1:0] ^ kk) : (b[1:0] + kk)};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_apply(input logic [AW-1:0] a, input logic [1:0] bwn, input logic [DW-1:0] d);
        for (int l = 0; l < LANES; l++)
            if (!bwn[l]) mdl[a][l*LW +: LW] = d[l*LW +: LW];
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic cmd(input bit a_n, input bit b, input bit c_n, input bit adv, input bit wrn,
                       input bit ilv, input logic [AW-1:0] a, input logic [1:0] bwn);
        clk_en_n = 1'b0; cs_a_n = a_n; cs_b = b; cs_c_n = c_n;
        adv_ld = adv; wr_n = wrn; burst_ilv = ilv; addr = a; byte_wr_n = bwn;
        step();
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit ilv, input logic [1:0] bwn);
        cmd(0, 1, 0, 0, 1, ilv, a, bwn);
    endtask
    task automatic wr(input logic [AW-1:0] a, input bit ilv, input logic [1:0] bwn);
        cmd(0, 1, 0, 0, 0, ilv, a, bwn);
    endtask
    task automatic adv(input logic [1:0] bwn);
        cmd(1, 0, 1, 1, 1, 0, '0, bwn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        rst_n = 1'b0; clk_en_n = 1'b0; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
        adv_ld = 1'b0; wr_n = 1'b1; burst_ilv = 1'b0; addr = '0; byte_wr_n = '1;
        wdata = '0; oe_n = 1'b0;
        step(); step();
        chk("R12 oe after reset", DW'(rdata_oe), DW'(0));
        chk("R12 data after reset", rdata, '0);
        rst_n = 1'b1;
        step();
        rd(5, 0, 2'b11);
        chk("R12 array zero", rdata, '0);

        // pipelined writes of every address, data one edge behind its command
        for (int i = 0; i < 16; i++) begin
            if (i > 0) begin
                wdata = dat(i - 1);
                model_apply(AW'(i - 1), 2'b00, wdata);
            end
            wr(AW'(i), 0, 2'b00);
            chk("R11 no drive on write", DW'(rdata_oe), DW'(0));
        end
        wdata = dat(15);
        model_apply(15, 2'b00, wdata);
        rd(0, 0, 2'b11);
        chk("R3 read after writes", rdata, mdl[0]);
        for (int i = 1; i < 16; i++) begin
            wdata = '0;
            rd(AW'(i), 0, 2'b11);
            chk("R9 back-to-back read", rdata, mdl[i]);
            chk("R9 drive on read", DW'(rdata_oe), DW'(1));
        end

        // alternating write/read of the same address, full rate
        for (int i = 0; i < 16; i++) begin
            wdata = '0;
            wr(AW'(i), 0, 2'(i));
            wdata = dat(100 + i);
            model_apply(AW'(i), 2'(i), wdata);
            rd(AW'(i), 0, 2'b11);
            chk("R10 merged bypass", rdata, mdl[i]);
        end
        wdata = '0;
        for (int i = 0; i < 16; i++) begin
            rd(AW'(i), 0, 2'b11);
            chk("R7 committed lanes", rdata, mdl[i]);
        end

        // all masks high writes nothing
        wr(2, 0, 2'b11);
        wdata = 18'h2AAAA;
        rd(2, 0, 2'b11);
        chk("R7 empty mask bypass", rdata, mdl[2]);
        wdata = '0;
        rd(2, 0, 2'b11);
        chk("R7 empty mask array", rdata, mdl[2]);

        // byte masks during a read do nothing
        rd(4, 0, 2'b00);
        wdata = 18'h15555;
        rd(4, 0, 2'b00);
        chk("R8 read masks ignored", rdata, mdl[4]);
        wdata = '0;
        rd(4, 0, 2'b11);
        chk("R8 read masks ignored later", rdata, mdl[4]);

        // burst read sweep, both orders, through the wrap
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int b = 0; b < 16; b++) begin
                rd(AW'(b), ilv[0], 2'b11);
                chk(ilv ? "R5 beat0" : "R6 beat0", rdata, mdl[baddr(AW'(b), 0, ilv[0])]);
                for (int k = 1; k < 5; k++) begin
                    adv(2'b11);
                    chk(ilv ? "R5 interleaved beat" : "R6 linear beat", rdata,
                        mdl[baddr(AW'(b), k, ilv[0])]);
                end
            end
        end

        // burst write, interleaved, then read back
        wr(13, 1, 2'b00);
        for (int k = 1; k < 4; k++) begin
            wdata = dat(200 + k);
            model_apply(baddr(13, k - 1, 1), 2'b00, wdata);
            adv(2'b00);
        end
        wdata = dat(204);
        model_apply(baddr(13, 3, 1), 2'b00, wdata);
        rd(12, 0, 2'b11);
        chk("R4 burst write beat", rdata, mdl[12]);
        wdata = '0;
        for (int k = 1; k < 4; k++) begin
            adv(2'b11);
            chk("R4 burst write beat", rdata, mdl[12 + k]);
        end

        // chip-select decode
        for (int c = 0; c < 8; c++) begin
            cmd(c[2], c[1], c[0], 0, 1, 0, 5, 2'b11);
            chk("R2 select decode", DW'(rdata_oe), DW'(c == 2));
            chk("R2 select data", rdata, (c == 2) ? mdl[5] : '0);
        end
        cmd(1, 0, 1, 0, 1, 0, 5, 2'b11);
        adv(2'b11);
        chk("R4 continued deselect", DW'(rdata_oe), DW'(0));

        // output enable
        oe_n = 1'b1;
        rd(5, 0, 2'b11);
        chk("R11 oe high no drive", DW'(rdata_oe), DW'(0));
        chk("R11 oe high zero data", rdata, '0);
        oe_n = 1'b0;
        #1;
        chk("R11 oe low drives", rdata, mdl[5]);

        // stall during a read burst
        rd(9, 0, 2'b11);
        chk("R1 before stall", rdata, mdl[9]);
        clk_en_n = 1'b1; adv_ld = 1'b0; addr = 1; wr_n = 1'b0;
        for (int s = 0; s < 3; s++) begin
            step();
            chk("R1 stalled data", rdata, mdl[9]);
            chk("R1 stalled oe", DW'(rdata_oe), DW'(1));
        end
        adv(2'b11);
        chk("R1 resumes burst", rdata, mdl[baddr(9, 1, 0)]);

        // stall between a write command and its data
        wr(10, 0, 2'b00);
        clk_en_n = 1'b1;
        wdata = 18'h3FFFF;
        step(); step();
        wdata = dat(300);
        model_apply(10, 2'b00, wdata);
        rd(10, 0, 2'b11);
        chk("R1 write data after stall", rdata, mdl[10]);
        wdata = '0;
        rd(10, 0, 2'b11);
        chk("R1 write committed after stall", rdata, mdl[10]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule